// File: doc/BRIEF.md
# Strap-Selected GPIO Ownership Multiplexer

This block decides who drives two general-purpose pins. The first possible owner is the ordinary GPIO logic, which has a direction register and a data register. The second is a serial-interface control register that sits in configuration space. When configuration space owns the pins, pin 0 serves as a serial clock line and pin 1 as a serial data line.

Ownership is chosen once after each reset. A fixed number of clock cycles after reset is released, the block samples a strap input (which has a pull-up off-chip) and the two pin levels together. A low strap asks for configuration-space ownership. The request is refused if either pin reads low in that same sample. The result is latched and exported as a status bit, and it holds until the next reset.

After the choice, the losing register set cannot move the pins. The GPIO data register still returns the live pin levels, whichever mode is active. All three registers are reached through a small synchronous read/write port. Each read returns its data one clock after the address is presented.

Top module: `pin_owner_mux`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, cfg_mode is 0, both pin_oe bits are 0 and reg_rdata is 0.
- R2: cfg_mode stays 0 on every clock edge before the SAMPLE_DLY-th rising edge after reset release (SAMPLE_DLY = 16 by default).
- R3: If strap_i is 1 at the SAMPLE_DLY-th edge, cfg_mode is 0 after that edge.
- R4: If strap_i is 0 at the SAMPLE_DLY-th edge, cfg_mode after that edge is 1 only when both pin_in bits are 1; if either pin bit is 0, cfg_mode is 0.
- R5: Once the decision is taken, cfg_mode keeps its value whatever strap_i and pin_in do, until the next reset.
- R6: When cfg_mode is 0, the register at address 0 is the GPIO direction register and the register at address 1 is the GPIO data register. Bit i of address 0 set to 1 drives pin i (pin_oe[i]=1), and bit i of address 1 gives pin_out[i]. Pins change on the edge that takes the write. Address 0 reads back the full written byte.
- R7: When cfg_mode is 1, writes to address 0 or address 1 are discarded. pin_oe and pin_out do not change, and address 0 keeps reading its old value.
- R8: A read of address 1 returns the live pin_in levels in bits [1:0] and zeros above, in either mode. Address 3 reads 0. Every read shows its data one edge after the address.
- R9: When cfg_mode is 1, the register at address 2 owns the pins. Bit 0 sets the pin 0 (clock) level, bit 1 sets the pin 1 (data) level, bit 2 enables the pin 0 drive and bit 3 enables the pin 1 drive. A clear enable tri-states its pin. The register reads back bits [3:0].
- R10: When cfg_mode is 0, address 2 reads 0 and writes to it have no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 1 | Ownership strap, low requests configuration-space control |
| pin_in | input | NPIN | Sensed pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 direction, 1 data, 2 serial control |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, one cycle after address |
| pin_out | output | NPIN | Pin output level |
| pin_oe | output | NPIN | Pin output enable, 1 drives |
| cfg_mode | output | 1 | Latched ownership: 1 when configuration space controls the pins |

## Verification
The hardest situation to reach from the ports is the single sample edge, where a pin-low veto has to override a strap that requests ownership. The bench walks a table of strap and pin combinations through a fresh reset each time. It checks cfg_mode one edge before the sample and again on the sample edge itself. Once configuration mode has been entered, it writes the GPIO registers and confirms that the pins stay where the serial control register put them.

// File: rtl/pin_owner_pkg.sv
`timescale 1ns/1ps
package pin_owner_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR  = 2'd0,
    RA_DATA = 2'd1,
    RA_SCTL = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/strap_sampler.sv
`timescale 1ns/1ps
module strap_sampler #(
  parameter int SAMPLE_DLY = 16,
  parameter int NPIN       = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strap_i,
  input  logic [NPIN-1:0] pin_in,
  output logic            cfg_mode_o
);
  localparam int CW = $clog2(SAMPLE_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_DLY - 1);

  logic [CW-1:0] wait_cnt;
  logic          decided;

  // one-shot decision: low strap asks, any low pin vetoes
  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt   <= '0;
      decided    <= 1'b0;
      cfg_mode_o <= 1'b0;
    end else if (!decided) begin
      if (wait_cnt == LAST) begin
        decided    <= 1'b1;
        cfg_mode_o <= ~strap_i & (&pin_in);
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
  import pin_owner_pkg::*;
#(
  parameter int NPIN = 2,
  parameter int DW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mode,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [DW-1:0]     dir_q,
  output logic [NPIN-1:0]   data_q,
  output logic [2*NPIN-1:0] sctl_q,
  output logic [DW-1:0]     rdata
);
  localparam int SW = 2 * NPIN;

  reg_addr_e ra;
  assign ra = reg_addr_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      data_q <= '0;
      sctl_q <= '0;
    end else if (we) begin
      unique case (ra)
        RA_DIR:  if (!cfg_mode) dir_q  <= wdata;
        RA_DATA: if (!cfg_mode) data_q <= wdata[NPIN-1:0];
        RA_SCTL: if (cfg_mode)  sctl_q <= wdata[SW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (ra)
        RA_DIR:  rdata <= dir_q;
        RA_DATA: rdata <= {{(DW-NPIN){1'b0}}, pin_in};
        RA_SCTL: rdata <= cfg_mode ? {{(DW-SW){1'b0}}, sctl_q} : '0;
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pin_drive_mux.sv
`timescale 1ns/1ps
module pin_drive_mux #(
  parameter int NPIN = 2
) (
  input  logic              cfg_mode,
  input  logic [NPIN-1:0]   gp_dir,
  input  logic [NPIN-1:0]   gp_val,
  input  logic [2*NPIN-1:0] sctl,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_comb begin
      if (cfg_mode) begin
        pin_out[i] = sctl[i];
        pin_oe[i]  = sctl[NPIN+i];
      end else begin
        pin_out[i] = gp_val[i];
        pin_oe[i]  = gp_dir[i];
      end
    end
  end
endmodule

// File: rtl/pin_owner_mux.sv
`timescale 1ns/1ps
module pin_owner_mux
  import pin_owner_pkg::*;
#(
  parameter int SAMPLE_DLY = 16,
  parameter int NPIN       = 2,
  parameter int DW         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_i,
  input  logic [NPIN-1:0]   pin_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              cfg_mode
);
  logic [DW-1:0]     dir_q;
  logic [NPIN-1:0]   data_q;
  logic [2*NPIN-1:0] sctl_q;

  strap_sampler #(.SAMPLE_DLY(SAMPLE_DLY), .NPIN(NPIN)) u_sample (
    .clk(clk), .rst(rst), .strap_i(strap_i), .pin_in(pin_in),
    .cfg_mode_o(cfg_mode)
  );

  gpio_regs #(.NPIN(NPIN), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .we(reg_we),
    .addr(reg_addr), .wdata(reg_wdata), .pin_in(pin_in),
    .dir_q(dir_q), .data_q(data_q), .sctl_q(sctl_q), .rdata(reg_rdata)
  );

  pin_drive_mux #(.NPIN(NPIN)) u_mux (
    .cfg_mode(cfg_mode), .gp_dir(dir_q[NPIN-1:0]), .gp_val(data_q),
    .sctl(sctl_q), .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/pin_owner_chk.sv
`timescale 1ns/1ps
module pin_owner_chk #(
  parameter int SAMPLE_DLY = 16,
  parameter int NPIN       = 2,
  parameter int DW         = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            strap_i,
  input logic [NPIN-1:0] pin_in,
  input logic            reg_we,
  input logic [1:0]      reg_addr,
  input logic [DW-1:0]   reg_rdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic            cfg_mode
);
  localparam int CW = $clog2(SAMPLE_DLY + 1);
  localparam logic [CW-1:0] EDGE_N = CW'(SAMPLE_DLY - 1);
  localparam logic [CW-1:0] DONE_N = CW'(SAMPLE_DLY);

  logic [CW-1:0] obs_cnt;
  always_ff @(posedge clk) begin
    if (rst) obs_cnt <= '0;
    else if (obs_cnt != DONE_N) obs_cnt <= obs_cnt + 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_oe == '0 && !cfg_mode && reg_rdata == '0));

  assert_no_early_mode_R2: assert property (@(posedge clk) disable iff (rst)
    (obs_cnt < DONE_N) |-> !cfg_mode);

  assert_strap_high_off_R3: assert property (@(posedge clk) disable iff (rst)
    (obs_cnt == EDGE_N && strap_i) |=> !cfg_mode);

  assert_strap_low_on_R4: assert property (@(posedge clk) disable iff (rst)
    (obs_cnt == EDGE_N && !strap_i && (&pin_in)) |=> cfg_mode);

  assert_mode_held_R5: assert property (@(posedge clk) disable iff (rst)
    (obs_cnt == DONE_N) |=> $stable(cfg_mode));

  assert_gpio_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && reg_we && (reg_addr == 2'd0 || reg_addr == 2'd1))
      |=> ($stable(pin_oe) && $stable(pin_out)));

  assert_sctl_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mode && reg_addr == 2'd2) |=> reg_rdata == '0);

  assert_sctl_write_dead_R10: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mode && obs_cnt == DONE_N && reg_we && reg_addr == 2'd2)
      |=> ($stable(pin_oe) && $stable(pin_out)));
endmodule

bind pin_owner_mux pin_owner_chk #(
  .SAMPLE_DLY(SAMPLE_DLY), .NPIN(NPIN), .DW(DW)
) u_chk (
  .clk(clk), .rst(rst), .strap_i(strap_i), .pin_in(pin_in),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .cfg_mode(cfg_mode)
);

// File: tb/test_pin_owner_mux.sv
`timescale 1ns/1ps
module test_pin_owner_mux;
  localparam int DLY = 16;
  localparam int NP  = 2;
  localparam int DW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strap_i = 1'b1;
  logic [NP-1:0] pin_in = 2'b11;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic          cfg_mode;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pin_owner_mux #(.SAMPLE_DLY(DLY), .NPIN(NP), .DW(DW)) i_pin_owner_mux (
    .clk(clk), .rst(rst), .strap_i(strap_i), .pin_in(pin_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .cfg_mode(cfg_mode)
  );

  // {strap, pin1, pin0, expected cfg_mode}
  localparam logic [3:0] VEC [6] = '{
    4'b1_11_0, 4'b1_00_0, 4'b0_11_1, 4'b0_10_0, 4'b0_01_0, 4'b0_00_0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    step(1);
    d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    step(1);
    // R1: values held during reset
    chk("R1 oe in reset", 32'(pin_oe), 0);
    chk("R1 mode in reset", 32'(cfg_mode), 0);
    chk("R1 rdata in reset", 32'(reg_rdata), 0);

    for (int v = 0; v < 6; v++) begin
      strap_i = VEC[v][3];
      pin_in  = VEC[v][2:1];
      do_reset();
      chk("R1 mode after release", 32'(cfg_mode), 0);
      step(DLY - 1);
      chk("R2 mode before sample edge", 32'(cfg_mode), 0);
      step(1);
      chk(VEC[v][3] ? "R3 strap high" : "R4 strap low / pin veto",
          32'(cfg_mode), 32'(VEC[v][0]));
      strap_i = ~strap_i;
      pin_in  = ~pin_in;
      step(4);
      chk("R5 decision held", 32'(cfg_mode), 32'(VEC[v][0]));
    end

    // normal mode
    strap_i = 1'b1; pin_in = 2'b11;
    do_reset();
    step(DLY);
    chk("R3 normal mode", 32'(cfg_mode), 0);
    wr(2'd0, 8'hA1);
    wr(2'd1, 8'hF3);
    chk("R6 oe from dir reg", 32'(pin_oe), 32'h1);
    chk("R6 out from data reg", 32'(pin_out), 32'h3);
    rd(2'd0, d);
    chk("R6 dir readback", 32'(d), 32'hA1);
    wr(2'd2, 8'h0F);
    chk("R10 sctl write no effect oe", 32'(pin_oe), 32'h1);
    chk("R10 sctl write no effect out", 32'(pin_out), 32'h3);
    rd(2'd2, d);
    chk("R10 sctl reads zero", 32'(d), 0);
    pin_in = 2'b01;
    rd(2'd1, d);
    chk("R8 data reads pins normal", 32'(d), 32'h1);
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h00);
    chk("R6 oe pin1 only", 32'(pin_oe), 32'h2);
    chk("R6 out zero", 32'(pin_out), 0);

    // configuration-space mode
    strap_i = 1'b0; pin_in = 2'b11;
    do_reset();
    step(DLY);
    chk("R4 cfg mode entered", 32'(cfg_mode), 1);
    chk("R9 tristate at entry", 32'(pin_oe), 0);
    wr(2'd2, 8'h06);
    chk("R9 clk drive only oe", 32'(pin_oe), 32'h1);
    chk("R9 levels", 32'(pin_out), 32'h2);
    wr(2'd2, 8'h0D);
    chk("R9 both driven oe", 32'(pin_oe), 32'h3);
    chk("R9 both driven out", 32'(pin_out), 32'h1);
    rd(2'd2, d);
    chk("R9 sctl readback", 32'(d), 32'h0D);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFE);
    chk("R7 gpio write no oe effect", 32'(pin_oe), 32'h3);
    chk("R7 gpio write no out effect", 32'(pin_out), 32'h1);
    rd(2'd0, d);
    chk("R7 dir write dropped", 32'(d), 0);
    pin_in = 2'b10;
    rd(2'd1, d);
    chk("R8 data reads pins cfg", 32'(d), 32'h2);
    rd(2'd3, d);
    chk("R8 unused address", 32'(d), 0);

    finish_run();
  end
endmodule